// File: doc/BRIEF.md
# Burst EDO DRAM Controller

This block sits between a 32-bit CPU bus and an EDO DRAM array and runs from a single 50 MHz clock. It serves two kinds of access. One is a single longword write. The other is a cache-line burst read over a line of 16 bytes, which is four longwords. The controller multiplexes the row and column address onto the DRAM address pins. It drives the row and column strobes and the write enable, and it answers the CPU with a data acknowledge on every beat. On the final beat it also raises a last-beat flag.

A burst read has a variable length and never wraps. It begins at the longword that address bits [3:2] select and moves upward until it reaches the end of the line, so it carries 4 minus the starting index beats. The page stays open for the whole burst. Between beats only the column strobe toggles, and only the two low column bits advance. The first beat arrives 5 clocks after the access starts and each later beat follows 2 clocks after the one before it.

An internal interval counter requests CAS-before-RAS refresh. The controller grants that refresh only while no CPU access is in progress. After every access or refresh cycle, the row strobe returns high for a precharge interval of at least two clocks.

Top module: `edo_burst_ctrl`

## Requirements
- R1: While and after reset, `ras_n`, `cas_n` and `dram_we_n` are high and `ack` and `last` are low until a request is accepted.
- R2: An access starts in the clock where `ras_n` goes low while `cas_n` is high. In that clock `dram_addr` carries the row, which is `addr[21:12]`. In the next clock it carries the column, which is `addr[11:2]`.
- R3: Counting the access-start clock as clock 1, a burst read raises `ack` in clocks 5, 7, 9 and 11, and in no other clock.
- R4: A read beginning at line index `addr[3:2]` returns exactly 4 minus that index beats. They come from ascending longwords and end at index 3 with no wrap to index 0. Between beats the two low column bits of `dram_addr` increase by one.
- R5: `last` is high together with the final `ack` of an access and at no other time.
- R6: `ras_n` stays low from the access start to the final beat. `cas_n` is high for exactly one clock between consecutive read beats.
- R7: A write holds `dram_we_n` and `cas_n` low in clock 3. It acknowledges with `ack` and `last` in clock 4, and the data is stored at the addressed longword.
- R8: After an access, `ras_n` stays high for at least 2 clocks before it falls again.
- R9: When the controller is idle, a refresh starts every `REF_INTERVAL` clocks. It takes the form of a CAS-before-RAS cycle: `cas_n` falls while `ras_n` is high, then `ras_n` falls. No `ack` occurs during it and `dram_we_n` stays high.
- R10: A refresh that falls due during an access is held back until the access and its precharge are done, and it then runs without waiting for the next interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 50 MHz clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Access request, held until the last acknowledge |
| wr | input | 1 | 1 = single longword write, 0 = burst read |
| addr | input | 22 | CPU byte address |
| wdata | input | 32 | Write data |
| ack | output | 1 | Per-beat data acknowledge |
| last | output | 1 | Marks the final beat of an access |
| rdata | output | 32 | Read data to the CPU |
| ras_n | output | 1 | DRAM row strobe, active low |
| cas_n | output | 1 | DRAM column strobe, active low |
| dram_we_n | output | 1 | DRAM write enable, active low |
| dram_addr | output | 10 | Multiplexed row/column address |
| dram_wdata | output | 32 | Data driven to the DRAM |
| dram_rdata | input | 32 | Data returned by the DRAM |

## Verification
The bench sends reads from each of the four line offsets. A controller that wrapped would return too many beats at offsets 4, 8 and C, and one that counted beats wrongly would raise `last` early or late. Beat timing is checked clock by clock against the 5-2-2-2 pattern, so an off-by-one in the first-access wait or between beats shows up as a missing or misplaced acknowledge. Refresh is checked in two situations: its period while the controller is idle, and a refresh that falls due inside a full-line burst. A design that split the burst would stretch the beat spacing or raise `ras_n` in the middle of the burst. A design that lost the pending request would not refresh right after the precharge.

// File: rtl/edo_pkg.sv
package edo_pkg;

    localparam int LINE_WORDS  = 4;
    localparam int RD_CAS_CYC  = 2;
    localparam int PRE_CYC     = 2;
    localparam int REF_RAS_CYC = 3;
    localparam int TMR_W       = 3;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ROW,
        ST_RCD,
        ST_RD_CAS,
        ST_RD_BEAT,
        ST_CAS_UP,
        ST_WR_CAS,
        ST_WR_ACK,
        ST_PRE,
        ST_REF_CAS,
        ST_REF_RAS
    } seq_state_e;

    typedef struct packed {
        logic ras_n;
        logic cas_n;
        logic we_n;
        logic col_sel;
        logic ack;
    } pin_ctl_t;

    function automatic pin_ctl_t ctl_for(seq_state_e s);
        pin_ctl_t c;
        c = '{ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1, col_sel: 1'b0, ack: 1'b0};
        case (s)
            ST_ROW:     c.ras_n = 1'b0;
            ST_RCD:     begin c.ras_n = 1'b0; c.col_sel = 1'b1; end
            ST_RD_CAS:  begin c.ras_n = 1'b0; c.cas_n = 1'b0; c.col_sel = 1'b1; end
            ST_RD_BEAT: begin c.ras_n = 1'b0; c.cas_n = 1'b0; c.col_sel = 1'b1; c.ack = 1'b1; end
            ST_CAS_UP:  begin c.ras_n = 1'b0; c.col_sel = 1'b1; end
            ST_WR_CAS:  begin c.ras_n = 1'b0; c.cas_n = 1'b0; c.we_n = 1'b0; c.col_sel = 1'b1; end
            ST_WR_ACK:  begin
                c.ras_n = 1'b0; c.cas_n = 1'b0; c.we_n = 1'b0; c.col_sel = 1'b1; c.ack = 1'b1;
            end
            ST_REF_CAS: c.cas_n = 1'b0;
            ST_REF_RAS: begin c.ras_n = 1'b0; c.cas_n = 1'b0; end
            default:    ;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/edo_refresh_timer.sv
module edo_refresh_timer #(
    parameter int INTERVAL = 780
) (
    input  logic clk,
    input  logic rst,
    input  logic grant,
    output logic pending
);
    localparam int CW = $clog2(INTERVAL + 1);

    logic [CW-1:0] cnt;
    logic          tick;

    assign tick = (cnt == CW'(INTERVAL - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            pending <= 1'b0;
        end else begin
            cnt <= tick ? '0 : cnt + CW'(1);
            if (tick)
                pending <= 1'b1;
            else if (grant)
                pending <= 1'b0;
        end
    end
endmodule

// File: rtl/edo_beat_counter.sv
module edo_beat_counter #(
    parameter int WORDS = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       load,
    input  logic [$clog2(WORDS)-1:0]   start_idx,
    input  logic                       step,
    output logic [$clog2(WORDS)-1:0]   idx,
    output logic                       at_end
);
    localparam int IW = $clog2(WORDS);

    always_ff @(posedge clk) begin
        if (rst)
            idx <= '0;
        else if (load)
            idx <= start_idx;
        else if (step)
            idx <= idx + IW'(1);
    end

    // no wrap: the burst ends on the top word of the line
    assign at_end = (idx == IW'(WORDS - 1));
endmodule

// File: rtl/edo_sequencer.sv
module edo_sequencer
    import edo_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       req,
    input  logic       wr,
    input  logic       ref_pending,
    input  logic       at_end,
    output seq_state_e state,
    output logic       ref_grant,
    output logic       load,
    output logic       step,
    output logic       wr_q
);
    seq_state_e       nxt;
    logic [TMR_W-1:0] tmr, tmr_nxt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            tmr   <= '0;
            wr_q  <= 1'b0;
        end else begin
            state <= nxt;
            tmr   <= tmr_nxt;
            if (load) wr_q <= wr;
        end
    end

    always_comb begin
        nxt       = state;
        tmr_nxt   = (tmr == '0) ? '0 : tmr - TMR_W'(1);
        ref_grant = 1'b0;
        load      = 1'b0;
        step      = 1'b0;
        case (state)
            ST_IDLE: begin
                if (ref_pending) begin
                    ref_grant = 1'b1;
                    nxt       = ST_REF_CAS;
                end else if (req) begin
                    load = 1'b1;
                    nxt  = ST_ROW;
                end
            end
            ST_ROW:  nxt = ST_RCD;
            ST_RCD: begin
                nxt     = wr_q ? ST_WR_CAS : ST_RD_CAS;
                tmr_nxt = TMR_W'(RD_CAS_CYC - 1);
            end
            ST_RD_CAS:  if (tmr == '0) nxt = ST_RD_BEAT;
            ST_RD_BEAT: begin
                if (at_end) begin
                    nxt     = ST_PRE;
                    tmr_nxt = TMR_W'(PRE_CYC - 1);
                end else begin
                    step = 1'b1;
                    nxt  = ST_CAS_UP;
                end
            end
            ST_CAS_UP:  nxt = ST_RD_BEAT;
            ST_WR_CAS:  nxt = ST_WR_ACK;
            ST_WR_ACK: begin
                nxt     = ST_PRE;
                tmr_nxt = TMR_W'(PRE_CYC - 1);
            end
            ST_PRE:     if (tmr == '0) nxt = ST_IDLE;
            ST_REF_CAS: begin
                nxt     = ST_REF_RAS;
                tmr_nxt = TMR_W'(REF_RAS_CYC - 1);
            end
            ST_REF_RAS: begin
                if (tmr == '0) begin
                    nxt     = ST_PRE;
                    tmr_nxt = TMR_W'(PRE_CYC - 1);
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/edo_burst_ctrl.sv
module edo_burst_ctrl
    import edo_pkg::*;
#(
    parameter int ROW_W        = 10,
    parameter int COL_W        = 10,
    parameter int DATA_W       = 32,
    parameter int REF_INTERVAL = 780,
    localparam int IDX_W  = $clog2(LINE_WORDS),
    localparam int CPU_AW = ROW_W + COL_W + 2,
    localparam int MA_W   = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              wr,
    input  logic [CPU_AW-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              ack,
    output logic              last,
    output logic [DATA_W-1:0] rdata,
    output logic              ras_n,
    output logic              cas_n,
    output logic              dram_we_n,
    output logic [MA_W-1:0]   dram_addr,
    output logic [DATA_W-1:0] dram_wdata,
    input  logic [DATA_W-1:0] dram_rdata
);
    seq_state_e        state;
    pin_ctl_t          ctl;
    logic              ref_pending, ref_grant, load, step, wr_q, at_end;
    logic [IDX_W-1:0]  idx;
    logic [CPU_AW-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [ROW_W-1:0]  row;
    logic [COL_W-1:0]  column;

    edo_refresh_timer #(.INTERVAL(REF_INTERVAL)) u_ref (
        .clk(clk), .rst(rst), .grant(ref_grant), .pending(ref_pending)
    );

    edo_beat_counter #(.WORDS(LINE_WORDS)) u_beat (
        .clk(clk), .rst(rst), .load(load), .start_idx(addr[IDX_W+1:2]),
        .step(step), .idx(idx), .at_end(at_end)
    );

    edo_sequencer u_seq (
        .clk(clk), .rst(rst), .req(req), .wr(wr), .ref_pending(ref_pending),
        .at_end(at_end), .state(state), .ref_grant(ref_grant), .load(load),
        .step(step), .wr_q(wr_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (load) begin
            addr_q  <= addr;
            wdata_q <= wdata;
        end
    end

    assign row    = addr_q[CPU_AW-1 -: ROW_W];
    assign column = {addr_q[COL_W+1:IDX_W+2], idx};

    assign ctl        = ctl_for(state);
    assign ras_n      = ctl.ras_n;
    assign cas_n      = ctl.cas_n;
    assign dram_we_n  = ctl.we_n;
    assign dram_addr  = ctl.col_sel ? MA_W'(column) : MA_W'(row);
    assign dram_wdata = wdata_q;
    assign ack        = ctl.ack;
    assign last       = ctl.ack && (wr_q || at_end);
    assign rdata      = dram_rdata;
endmodule

// File: rtl/edo_ctrl_checker.sv
module edo_ctrl_checker #(
    parameter int MA_W  = 10,
    parameter int IDX_W = 2
) (
    input logic            clk,
    input logic            rst,
    input logic            ras_n,
    input logic            cas_n,
    input logic            we_n,
    input logic            ack,
    input logic            last,
    input logic [MA_W-1:0] dram_addr
);
    // R3
    beat_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (ack && !last) |=> !ack);
    // R3
    beat_next_chk: assert property (@(posedge clk) disable iff (rst)
        (ack && !last) |=> ##1 ack);
    // R4
    col_step_chk: assert property (@(posedge clk) disable iff (rst)
        (ack && !last) |=> ##1
        (dram_addr[IDX_W-1:0] == $past(dram_addr[IDX_W-1:0], 2) + IDX_W'(1)));
    // R5
    last_with_ack_chk: assert property (@(posedge clk) disable iff (rst)
        last |-> ack);
    // R6
    ack_strobes_chk: assert property (@(posedge clk) disable iff (rst)
        ack |-> (!ras_n && !cas_n));
    // R7
    we_in_row_chk: assert property (@(posedge clk) disable iff (rst)
        !we_n |-> !ras_n);
    // R8
    precharge_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ras_n) |=> ras_n);
    // R9
    cbr_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (ras_n && !cas_n) |-> (!ack && we_n));
endmodule

bind edo_burst_ctrl edo_ctrl_checker #(.MA_W(MA_W), .IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst(rst), .ras_n(ras_n), .cas_n(cas_n), .we_n(dram_we_n),
    .ack(ack), .last(last), .dram_addr(dram_addr)
);

// File: tb/tb_edo_burst_ctrl.sv
module tb_edo_burst_ctrl;
    localparam int REF_INT = 200;
    localparam int NVEC    = 14;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0;
    logic        wr = 1'b0;
    logic [21:0] addr = '0;
    logic [31:0] wdata = '0;
    logic        ack, last, ras_n, cas_n, dram_we_n;
    logic [31:0] rdata, dram_wdata, dram_rdata;
    logic [9:0]  dram_addr;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    edo_burst_ctrl #(.REF_INTERVAL(REF_INT)) dut (
        .clk(clk), .rst(rst), .req(req), .wr(wr), .addr(addr), .wdata(wdata),
        .ack(ack), .last(last), .rdata(rdata), .ras_n(ras_n), .cas_n(cas_n),
        .dram_we_n(dram_we_n), .dram_addr(dram_addr), .dram_wdata(dram_wdata),
        .dram_rdata(dram_rdata)
    );

    // DRAM model: 8 rows x 8 columns of longwords
    logic [31:0] mem    [64];
    logic [31:0] shadow [64];
    logic [2:0]  row_lat = '0;
    logic        ras_prev = 1'b1;

    always @(posedge clk) begin
        ras_prev <= ras_n;
        if (!ras_n && ras_prev) row_lat <= dram_addr[2:0];
        if (!ras_n && !cas_n && !dram_we_n) mem[{row_lat, dram_addr[2:0]}] <= dram_wdata;
    end
    assign dram_rdata = (!ras_n && !cas_n) ? mem[{row_lat, dram_addr[2:0]}] : '0;

    // {wr, addr, data}
    localparam logic [54:0] VEC [NVEC] = '{
        {1'b1, 22'h001010, 32'h11110000},
        {1'b1, 22'h001014, 32'h11110004},
        {1'b1, 22'h001018, 32'h11110008},
        {1'b1, 22'h00101C, 32'h1111000C},
        {1'b0, 22'h001010, 32'h0},
        {1'b0, 22'h001018, 32'h0},
        {1'b0, 22'h00101C, 32'h0},
        {1'b0, 22'h001014, 32'h0},
        {1'b1, 22'h003008, 32'hDEADBEEF},
        {1'b0, 22'h003000, 32'h0},
        {1'b0, 22'h003008, 32'h0},
        {1'b1, 22'h00200C, 32'h5A5AA5A5},
        {1'b0, 22'h002004, 32'h0},
        {1'b0, 22'h00200C, 32'h0}
    };

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int sidx(input logic [21:0] a, input int k);
        int w;
        w = int'(a[3:2]) + k;
        return (int'(a[14:12]) << 3) | (int'(a[4]) << 2) | (w & 3);
    endfunction

    task automatic run_access(input logic w, input logic [21:0] a, input logic [31:0] d);
        int  t, k, nb, exp_t;
        bit  found, done;
        @(negedge clk);
        req = 1'b1; wr = w; addr = a; wdata = d;
        found = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (!ras_n && cas_n) begin found = 1; break; end
        end
        chk(found, "R2 access start", 32'(found), 32'd1);
        chk(dram_addr == a[21:12], "R2 row address", 32'(dram_addr), 32'(a[21:12]));
        nb = 4 - int'(a[3:2]);
        k = 0; t = 1; done = 0;
        while (!done && t < 40) begin
            @(negedge clk);
            t++;
            if (t == 2) chk(dram_addr == a[11:2], "R2 column address", 32'(dram_addr), 32'(a[11:2]));
            chk(!ras_n, "R6 row held", 32'(ras_n), 32'd0);
            if (!w) begin
                exp_t = 5 + 2 * k;
                if (k > 0 && t == exp_t - 1) chk(cas_n, "R6 cas high between beats", 32'(cas_n), 32'd1);
                if (ack) begin
                    chk(t == exp_t, "R3 beat clock", 32'(t), 32'(exp_t));
                    chk(rdata == shadow[sidx(a, k)], "R4 beat data", rdata, shadow[sidx(a, k)]);
                    chk(last == (k == nb - 1), "R5 last flag", 32'(last), 32'(k == nb - 1));
                    k++;
                    if (last) done = 1;
                end else if (t == exp_t) begin
                    chk(1'b0, "R3 missing beat", 32'(t), 32'(exp_t));
                end
            end else begin
                if (t == 3) chk(!dram_we_n && !cas_n, "R7 write strobes", {dram_we_n, cas_n}, 32'd0);
                if (ack) begin
                    chk(t == 4, "R7 write ack clock", 32'(t), 32'd4);
                    chk(last, "R5 write last", 32'(last), 32'd1);
                    shadow[sidx(a, 0)] = d;
                    k = 1;
                    done = 1;
                end
            end
        end
        if (!w) chk(k == nb, "R4 beat count", 32'(k), 32'(nb));
        req = 1'b0;
        @(negedge clk);
        chk(ras_n, "R8 precharge 1", 32'(ras_n), 32'd1);
        @(negedge clk);
        chk(ras_n, "R8 precharge 2", 32'(ras_n), 32'd1);
    endtask

    task automatic wait_cbr(input int limit, output int waited, output bit found);
        found = 0; waited = 0;
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            waited++;
            if (ras_n && !cas_n) begin found = 1; break; end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        int  waited, gap;
        bit  found;
        for (int i = 0; i < 64; i++) begin
            mem[i]    = 32'hC0DE0000 + 32'(i) * 32'h00010101;
            shadow[i] = mem[i];
        end
        repeat (4) @(negedge clk);
        // R1 during reset
        chk(ras_n && cas_n && dram_we_n && !ack && !last, "R1 in reset",
            {ras_n, cas_n, dram_we_n, ack, last}, 32'b11100);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk(ras_n && cas_n && dram_we_n && !ack && !last, "R1 after reset",
            {ras_n, cas_n, dram_we_n, ack, last}, 32'b11100);

        for (int v = 0; v < NVEC; v++)
            run_access(VEC[v][54], VEC[v][53:32], VEC[v][31:0]);

        // R9: idle refresh shape and period
        wait_cbr(3 * REF_INT, waited, found);
        chk(found, "R9 refresh seen", 32'(found), 32'd1);
        @(negedge clk);
        chk(!ras_n && !cas_n && !ack, "R9 ras after cas", {ras_n, cas_n, ack}, 32'b000);
        wait_cbr(3 * REF_INT, waited, found);
        gap = waited + 1;
        chk(found && gap == REF_INT, "R9 refresh period", 32'(gap), 32'(REF_INT));

        // R10: refresh due inside a full-line burst waits for it
        repeat (REF_INT - 9) @(negedge clk);
        run_access(1'b0, 22'h001010, 32'h0);
        wait_cbr(6, waited, found);
        chk(found, "R10 deferred refresh runs", 32'(found), 32'd1);

        run_access(1'b0, 22'h003000, 32'h0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule